// File: doc/BRIEF.md
# CPU Interrupt Input Pin Conditioner

This block sits between a processor core's asynchronous control pins and its interrupt logic. Each pin first passes through a synchronizer. A change filter then keeps the last level accepted for every pin and raises an event only when the synchronized level differs from that stored level. The events are turned into a small pending-interrupt vector, a summary hard-interrupt request, a sticky core-stop request, a one-cycle hard-reset request and a time-base run enable.

The pins differ in polarity and sensitivity. External, system-management and soft-reset interrupts follow their pin level, active high. Machine check is taken only on a falling edge and stays latched. Checkstop and hard reset are active low. The time-base enable follows its pin.

The core removes latched pending bits with a clear strobe and a one-hot mask. Vectoring, priority encoding and exception entry belong to the core and are not part of this block.

Top module: `irq_pin_cond`

## Requirements
- R1: After reset, all outputs are 0: `pend_o`, `hard_irq_o`, `core_stop_o`, `hreset_req_o` and `tb_run_o`. The stored pin levels are reset to the inactive level of each pin.
- R2: `pin_i[0]` is the external interrupt, active high. Its level is copied into `pend_o[0]`. A pin change reaches the outputs on the third rising clock edge after the change.
- R3: `pin_i[1]` is the system-management interrupt, active high. Its level is copied into `pend_o[1]`.
- R4: `pin_i[2]` is the machine check, active low. A 1-to-0 transition sets `pend_o[2]`. A later rising edge does not clear it, and a level held low does not set it again.
- R5: `pin_i[3]` is checkstop-in, active low. A falling transition sets `core_stop_o`. The output stays 1 until `rst_ni` resets the block, whatever the pin does afterwards.
- R6: `pin_i[4]` is hard reset, active low. Each falling transition produces a `hreset_req_o` pulse exactly one cycle long.
- R7: `pin_i[5]` is soft reset, active high. Its level is copied into `pend_o[3]`.
- R8: `pin_i[6]` is the time-base enable. A high level sets `tb_run_o` to 1 and a low level sets it to 0.
- R9: `hard_irq_o` rises whenever any pending bit is set. It falls only when the whole pending vector is zero.
- R10: While `clr_i` is high, the pending bits selected by `clr_mask_i` are cleared at that clock edge. If a pin event sets the same bit at the same edge, the set wins.
- R11: Repeated equal levels produce no event. A level-sensitive bit that has been cleared while its pin stays active remains 0.
- R12: Bits of `pin_i` at index 7 and above have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | PIN_W | Asynchronous pins; index 0 ext, 1 smi, 2 mcheck_n, 3 ckstop_n, 4 hreset_n, 5 sreset, 6 tb_en; higher bits ignored |
| clr_i | input | 1 | Clear strobe from the core |
| clr_mask_i | input | 4 | One-hot mask of pending bits to clear |
| pend_o | output | 4 | Pending vector: 0 ext, 1 smi, 2 machine check, 3 soft reset |
| hard_irq_o | output | 1 | Hard-interrupt request |
| core_stop_o | output | 1 | Sticky core-stop request |
| hreset_req_o | output | 1 | One-cycle hard-reset request |
| tb_run_o | output | 1 | Time-base run enable |

## Verification
The bench uses the default parameters, PIN_W = 8 and SYNC_STAGES = 2. The eighth pin bit is a spare, so toggling it tests R12. With two synchronizer stages, every pin change reaches the outputs on a fixed third rising edge. This lets the bench line a pin change up with a clear strobe on the same edge. Random pin patterns, each held for several cycles, are checked against a level and edge model kept in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_PINS   = 7;
    localparam int PIN_EXT    = 0;
    localparam int PIN_SMI    = 1;
    localparam int PIN_MCHK_N = 2;
    localparam int PIN_CKST_N = 3;
    localparam int PIN_HRST_N = 4;
    localparam int PIN_SRST   = 5;
    localparam int PIN_TBEN   = 6;
    // inactive level of every pin: active-low pins idle high
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 7'b0011100;

    localparam int PEND_W = 4;
    localparam int P_EXT  = 0;
    localparam int P_SMI  = 1;
    localparam int P_MCK  = 2;
    localparam int P_SRST = 3;

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              hard;
        logic              stop;
        logic              hrst;
        logic              tb;
    } core_state_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int            W       = 7,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= RST_VAL;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/irqc_filter.sv
module irqc_filter #(
    parameter int            W       = 7,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        rise_o = lvl_i & ~prev_q;
        fall_o = ~lvl_i & prev_q;
        prev_d = prev_q ^ (rise_o | fall_o);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= RST_VAL;
        else         prev_q <= prev_d;
    end

    // R11: an accepted rise is never reported again on the next cycle
    no_repeat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] fall_i,
    input  logic                clr_i,
    input  logic [PEND_W-1:0]   clr_mask_i,
    output core_state_t         st_o
);
    core_state_t st_d, st_q;
    logic        set_any;

    always_comb begin
        st_d      = st_q;
        st_d.hrst = 1'b0;
        if (clr_i) st_d.pend = st_d.pend & ~clr_mask_i;

        if (rise_i[PIN_EXT])    st_d.pend[P_EXT]  = 1'b1;
        if (fall_i[PIN_EXT])    st_d.pend[P_EXT]  = 1'b0;
        if (rise_i[PIN_SMI])    st_d.pend[P_SMI]  = 1'b1;
        if (fall_i[PIN_SMI])    st_d.pend[P_SMI]  = 1'b0;
        if (rise_i[PIN_SRST])   st_d.pend[P_SRST] = 1'b1;
        if (fall_i[PIN_SRST])   st_d.pend[P_SRST] = 1'b0;
        if (fall_i[PIN_MCHK_N]) st_d.pend[P_MCK]  = 1'b1;
        if (fall_i[PIN_CKST_N]) st_d.stop         = 1'b1;
        if (fall_i[PIN_HRST_N]) st_d.hrst         = 1'b1;
        if (rise_i[PIN_TBEN])   st_d.tb           = 1'b1;
        if (fall_i[PIN_TBEN])   st_d.tb           = 1'b0;

        set_any = rise_i[PIN_EXT] | rise_i[PIN_SMI] | rise_i[PIN_SRST]
                | fall_i[PIN_MCHK_N];
        if (set_any)                 st_d.hard = 1'b1;
        else if (st_d.pend == '0)    st_d.hard = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign st_o = st_q;

    // R9
    hard_matches_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.hard == (|st_q.pend));
    // R4
    mck_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pend[P_MCK] && !(clr_i && clr_mask_i[P_MCK])) |=> st_q.pend[P_MCK]);
    // R5
    stop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.stop |=> st_q.stop);
    // R6
    hrst_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.hrst |=> !st_q.hrst);
    // R10
    clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && clr_mask_i[P_EXT] && !rise_i[PIN_EXT]) |=> !st_q.pend[P_EXT]);
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
    import irqc_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic              clr_i,
    input  logic [3:0]        clr_mask_i,
    output logic [3:0]        pend_o,
    output logic              hard_irq_o,
    output logic              core_stop_o,
    output logic              hreset_req_o,
    output logic              tb_run_o
);
    logic [NUM_PINS-1:0] lvl_s, rise_s, fall_s;
    core_state_t         st;
    logic                unused_hi;

    // spare pin bits are not part of the defined set
    assign unused_hi = ^pin_i[PIN_W-1:NUM_PINS];

    irqc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pin_i[NUM_PINS-1:0]),
        .q_o   (lvl_s)
    );

    irqc_filter #(.W(NUM_PINS), .RST_VAL(PIN_IDLE)) u_filter (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (lvl_s),
        .rise_o(rise_s),
        .fall_o(fall_s)
    );

    irqc_core u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise_s),
        .fall_i    (fall_s),
        .clr_i     (clr_i),
        .clr_mask_i(clr_mask_i),
        .st_o      (st)
    );

    assign pend_o       = st.pend;
    assign hard_irq_o   = st.hard;
    assign core_stop_o  = st.stop;
    assign hreset_req_o = st.hrst;
    assign tb_run_o     = st.tb;
endmodule

// File: tb/irq_pin_cond_tb.sv
`timescale 1ns/1ps
module irq_pin_cond_tb;
    localparam logic [7:0] IDLE = 8'b0001_1100;
    localparam int B_EXT = 0, B_SMI = 1, B_MCK = 2, B_CKS = 3,
                   B_HRS = 4, B_SRS = 5, B_TBE = 6, B_SPARE = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = IDLE;
    logic       clr = 1'b0;
    logic [3:0] clr_mask = '0;
    logic [3:0] pend;
    logic       hard, stop, hrst, tb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_pin_cond u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .clr_i(clr),
        .clr_mask_i(clr_mask), .pend_o(pend), .hard_irq_o(hard),
        .core_stop_o(stop), .hreset_req_o(hrst), .tb_run_o(tb)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic set_pin(input int idx, input logic v);
        pins[idx] = v;
    endtask

    task automatic wait3();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        pins = IDLE; clr = 1'b0; clr_mask = '0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clear(input logic [3:0] m);
        clr = 1'b1; clr_mask = m;
        @(negedge clk);
        clr = 1'b0; clr_mask = '0;
    endtask

    // expected pending vector from the requirements (R2 R3 R4 R7)
    function automatic logic [3:0] exp_pend(input logic [3:0] old, input logic [6:0] pv,
                                            input logic [6:0] nv);
        logic [3:0] r;
        r        = old;
        r[0]     = nv[B_EXT];
        r[1]     = nv[B_SMI];
        r[3]     = nv[B_SRS];
        if (pv[B_MCK] && !nv[B_MCK]) r[2] = 1'b1;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] e_pend;
        logic       e_stop;
        logic [6:0] prev7;
        void'($urandom(32'h1234_5a5a));
        do_reset();
        // R1 reset state
        check("R1 pend", pend, 0);
        check("R1 hard", hard, 0);
        check("R1 stop", stop, 0);
        check("R1 hreset", hrst, 0);
        check("R1 tb", tb, 0);

        // R2 external level
        set_pin(B_EXT, 1); wait3();
        check("R2 pend set", pend, 4'b0001);
        check("R9 hard on ext", hard, 1);
        set_pin(B_EXT, 0); wait3();
        check("R2 pend clr", pend, 0);
        check("R9 hard off", hard, 0);

        // R3 smi level
        set_pin(B_SMI, 1); wait3();
        check("R3 pend set", pend, 4'b0010);
        set_pin(B_SMI, 0); wait3();
        check("R3 pend clr", pend, 0);

        // R7 soft reset level
        set_pin(B_SRS, 1); wait3();
        check("R7 pend set", pend, 4'b1000);
        set_pin(B_SRS, 0); wait3();
        check("R7 pend clr", pend, 0);

        // R9 hard stays while any bit pending
        set_pin(B_EXT, 1); set_pin(B_SMI, 1); wait3();
        check("R9 two bits", pend, 4'b0011);
        set_pin(B_EXT, 0); wait3();
        check("R9 hard held", hard, 1);
        set_pin(B_SMI, 0); wait3();
        check("R9 hard drop", hard, 0);

        // R4 machine check falling edge, latched
        set_pin(B_MCK, 0); wait3();
        check("R4 mck set", pend, 4'b0100);
        set_pin(B_MCK, 1); wait3();
        check("R4 mck kept on rise", pend, 4'b0100);
        pulse_clear(4'b0100);
        check("R10 mck cleared", pend, 0);
        check("R9 hard after clear", hard, 0);
        set_pin(B_MCK, 0); wait3();
        check("R4 mck set again", pend, 4'b0100);
        pulse_clear(4'b0100);
        repeat (5) @(negedge clk);
        check("R4 low hold no reset", pend, 0);
        set_pin(B_MCK, 1); wait3();

        // R11 cleared level bit stays clear while pin held
        set_pin(B_EXT, 1); wait3();
        pulse_clear(4'b0001);
        repeat (5) @(negedge clk);
        check("R11 ext stays clear", pend, 0);
        check("R11 hard stays off", hard, 0);
        set_pin(B_EXT, 0); wait3();
        check("R11 fall no set", pend, 0);

        // R10 set wins over clear on the same edge
        set_pin(B_EXT, 1);
        repeat (2) @(negedge clk);
        clr = 1'b1; clr_mask = 4'b0001;
        @(negedge clk);
        clr = 1'b0; clr_mask = '0;
        check("R10 set wins", pend, 4'b0001);
        set_pin(B_EXT, 0); wait3();

        // R8 time base
        set_pin(B_TBE, 1); wait3();
        check("R8 tb run", tb, 1);
        set_pin(B_TBE, 0); wait3();
        check("R8 tb frozen", tb, 0);

        // R6 hard reset pulse
        set_pin(B_HRS, 0); wait3();
        check("R6 pulse high", hrst, 1);
        @(negedge clk);
        check("R6 pulse one cycle", hrst, 0);
        repeat (4) @(negedge clk);
        check("R6 held low no pulse", hrst, 0);
        set_pin(B_HRS, 1); wait3();
        check("R6 rise no pulse", hrst, 0);

        // R12 spare pin bit ignored
        set_pin(B_SPARE, 1); repeat (4) @(negedge clk);
        check("R12 pend", pend, 0);
        check("R12 flags", {hard, stop, hrst, tb}, 0);
        set_pin(B_SPARE, 0); repeat (4) @(negedge clk);
        check("R12 pend back", pend, 0);

        // R5 checkstop sticky until reset
        set_pin(B_CKS, 0); wait3();
        check("R5 stop set", stop, 1);
        set_pin(B_CKS, 1); wait3();
        check("R5 stop sticky", stop, 1);
        do_reset();
        check("R5 stop cleared by reset", stop, 0);

        // random level patterns against the bench model
        e_pend = '0; e_stop = 1'b0; prev7 = IDLE[6:0];
        for (int n = 0; n < 200; n++) begin
            logic [7:0] nv;
            nv = 8'($urandom);
            pins = nv;
            repeat (4) @(negedge clk);
            e_pend = exp_pend(e_pend, prev7, nv[6:0]);
            if (prev7[B_CKS] && !nv[B_CKS]) e_stop = 1'b1;
            check("RAND R2 R3 R4 R7 R12 pend", pend, e_pend);
            check("RAND R9 hard", hard, |e_pend);
            check("RAND R5 stop", stop, e_stop);
            check("RAND R8 tb", tb, nv[B_TBE]);
            check("RAND R6 no late pulse", hrst, 0);
            prev7 = nv[6:0];
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule